// File: doc/BRIEF.md
# SMBus Protocol Command Sequencer

This block turns one host command into the byte-level bus operations that an SMBus transaction needs. A register block supplies a 3-bit protocol code, an address byte (7-bit target address above a read flag in bit 0), a command byte and two data bytes, then pulses a launch strobe. The sequencer latches these operands and issues a series of requests to a byte-level bus master: start with an address byte, send a byte, receive a byte with a chosen acknowledge, and stop. Each request is held until the master answers with a done strobe. The strobe carries the target's acknowledge for start and send requests, and the received byte for receive requests.

When a transaction succeeds, the sequencer raises a one-cycle done pulse. In the same cycle it writes any bytes it read back into the data0 and data1 registers. A missing acknowledge, or a protocol code that has no sequence, produces a one-cycle error pulse, and no data register is written. For block data the sequencer uses no bus operation and passes the command to a separate block buffer engine. For the I2C-style block read it sets up the transfer, fetches the first byte, and leaves the bus open so that the block engine can carry on.

Top module: `smbus_seq`

## Requirements
- R1: After reset, busy, the bus request and every result pulse are low.
- R2: Bus request codes are 0 start, 1 send, 2 receive and 3 stop. Protocol code 0 (quick) issues a start carrying the address byte unchanged, then a stop, then a done pulse.
- R3: Protocol code 1 with read flag 0 issues a start with address bit 0 cleared, a send of the command byte, and a stop. With read flag 1 it issues a start with bit 0 set, a receive with not-acknowledge, and a stop, and the received byte goes to data0.
- R4: Protocol code 2 with read flag 0 sends the command byte and then data0. With read flag 1 it sends the command byte, repeats the start with bit 0 set, and receives one byte with not-acknowledge into data0.
- R5: Protocol code 3 with read flag 0 sends the command byte, data0 and then data1. With read flag 1 it sends the command byte, repeats the start in read direction, receives the low byte with acknowledge into data0, and receives the high byte with not-acknowledge into data1.
- R6: Protocol code 6 ignores the read flag. It issues a start with bit 0 cleared, sends data1, repeats the start with bit 0 set, and receives one byte with acknowledge. It then pulses the first-byte output with that byte on the block byte output. It issues no stop and no done pulse.
- R7: Protocol code 5 issues no bus request and pulses the block handoff output once, with no done or error pulse.
- R8: Protocol codes 4 and 7 issue no bus request and give one error pulse.
- R9: A not-acknowledge on any start or send request stops the sequence. The sequencer issues a stop, then gives an error pulse, with no done pulse and no data write.
- R10: Each accepted launch ends in exactly one one-cycle pulse among done, error, block handoff and first byte. Busy is high from the cycle after acceptance until that pulse, and it is low during the pulse. A launch presented during a result pulse is accepted.
- R11: A launch while busy is ignored. Operands are latched at acceptance, so later changes on the inputs do not alter the running sequence.
- R12: The data0 write strobe is high only with a done pulse of a read using codes 1, 2 or 3. The data1 write strobe is high only with a done pulse of a code 3 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Start a transaction with the operands below |
| proto_i | input | 3 | Protocol code |
| addr_i | input | 8 | Target address in bits 7:1, read flag in bit 0 |
| cmd_i | input | 8 | Command byte |
| data0_i | input | 8 | Data register 0 value |
| data1_i | input | 8 | Data register 1 value |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | Successful completion pulse (sets interrupt status) |
| err_o | output | 1 | Failure pulse (sets device error) |
| blk_go_o | output | 1 | Block data handoff pulse |
| first_byte_o | output | 1 | I2C-style block read first byte ready (set busy and byte done) |
| blk_byte_o | output | 8 | First byte of the I2C-style block read |
| d0_we_o | output | 1 | Write strobe for data0 |
| d0_wdata_o | output | 8 | Value for data0 |
| d1_we_o | output | 1 | Write strobe for data1 |
| d1_wdata_o | output | 8 | Value for data1 |
| bm_valid_o | output | 1 | Bus request valid, held until bm_done_i |
| bm_op_o | output | 2 | Bus request code: 0 start, 1 send, 2 receive, 3 stop |
| bm_byte_o | output | 8 | Address or data byte for start and send |
| bm_nack_o | output | 1 | Answer a receive with not-acknowledge |
| bm_done_i | input | 1 | Bus master finished the current request |
| bm_nak_i | input | 1 | Target did not acknowledge (start or send) |
| bm_rdata_i | input | 8 | Byte received (receive) |

## Verification
The two events that can share a cycle are the result pulse of one transaction and the acceptance of the next launch. The bench checks this by raising launch in the same cycle as a done pulse. It then confirms three things: the read byte is still written, busy rises again at once, and the bus log holds both sequences back to back with the second one's operands. A second collision places a launch, with changed operands and an illegal protocol code, in the middle of a running word read. This launch must leave no trace in the request log or in the result pulses.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;

   typedef enum logic [2:0] {
      PR_QUICK = 3'd0,
      PR_BYTE  = 3'd1,
      PR_BDATA = 3'd2,
      PR_WDATA = 3'd3,
      PR_PCALL = 3'd4,
      PR_BLOCK = 3'd5,
      PR_IBLK  = 3'd6,
      PR_RSVD  = 3'd7
   } proto_e;

   typedef enum logic [2:0] {
      K_START, K_SEND, K_RECV, K_STOP, K_DONE, K_FAIL, K_BLOCK, K_FIRST
   } step_kind_e;

   typedef enum logic [1:0] {
      BM_START = 2'd0, BM_SEND = 2'd1, BM_RECV = 2'd2, BM_STOP = 2'd3
   } bm_op_e;

   typedef enum logic [2:0] {
      SRC_NONE, SRC_ADDR_RAW, SRC_ADDR_WR, SRC_ADDR_RD, SRC_CMD, SRC_D0, SRC_D1
   } src_e;

   typedef enum logic [1:0] {
      DST_NONE, DST_D0, DST_D1, DST_BLK
   } dest_e;

   typedef struct packed {
      step_kind_e kind;
      src_e       src;
      logic       nack;
      dest_e      dest;
   } step_t;

   function automatic step_t mk_step(step_kind_e k, src_e s, logic n, dest_e d);
      step_t r;
      r.kind = k;
      r.src  = s;
      r.nack = n;
      r.dest = d;
      return r;
   endfunction

endpackage

// File: rtl/smbseq_step_table.sv
module smbseq_step_table
   import smbseq_pkg::*;
#(
   parameter int PROTO_W   = 3,
   parameter int MAX_STEPS = 8,
   localparam int IDX_W    = $clog2(MAX_STEPS)
) (
   input  logic [PROTO_W-1:0] proto_i,
   input  logic               rd_i,
   input  logic [IDX_W-1:0]   idx_i,
   output step_t              step_o
);

   logic   hi_bad;
   proto_e code;
   step_t  seq [MAX_STEPS];

   generate
      if (PROTO_W > 3) begin : g_wide_code
         assign hi_bad = |proto_i[PROTO_W-1:3];
      end else begin : g_exact_code
         assign hi_bad = 1'b0;
      end
   endgenerate

   assign code = proto_e'(proto_i[2:0]);

   always_comb begin
      for (int i = 0; i < MAX_STEPS; i++) begin
         seq[i] = mk_step(K_FAIL, SRC_NONE, 1'b0, DST_NONE);
      end
      if (!hi_bad) begin
         case (code)
            PR_QUICK: begin
               seq[0] = mk_step(K_START, SRC_ADDR_RAW, 1'b0, DST_NONE);
               seq[1] = mk_step(K_STOP,  SRC_NONE,     1'b0, DST_NONE);
               seq[2] = mk_step(K_DONE,  SRC_NONE,     1'b0, DST_NONE);
            end
            PR_BYTE: begin
               if (rd_i) begin
                  seq[0] = mk_step(K_START, SRC_ADDR_RD, 1'b0, DST_NONE);
                  seq[1] = mk_step(K_RECV,  SRC_NONE,    1'b1, DST_D0);
               end else begin
                  seq[0] = mk_step(K_START, SRC_ADDR_WR, 1'b0, DST_NONE);
                  seq[1] = mk_step(K_SEND,  SRC_CMD,     1'b0, DST_NONE);
               end
               seq[2] = mk_step(K_STOP, SRC_NONE, 1'b0, DST_NONE);
               seq[3] = mk_step(K_DONE, SRC_NONE, 1'b0, DST_NONE);
            end
            PR_BDATA: begin
               seq[0] = mk_step(K_START, SRC_ADDR_WR, 1'b0, DST_NONE);
               seq[1] = mk_step(K_SEND,  SRC_CMD,     1'b0, DST_NONE);
               if (rd_i) begin
                  seq[2] = mk_step(K_START, SRC_ADDR_RD, 1'b0, DST_NONE);
                  seq[3] = mk_step(K_RECV,  SRC_NONE,    1'b1, DST_D0);
                  seq[4] = mk_step(K_STOP,  SRC_NONE,    1'b0, DST_NONE);
                  seq[5] = mk_step(K_DONE,  SRC_NONE,    1'b0, DST_NONE);
               end else begin
                  seq[2] = mk_step(K_SEND, SRC_D0,   1'b0, DST_NONE);
                  seq[3] = mk_step(K_STOP, SRC_NONE, 1'b0, DST_NONE);
                  seq[4] = mk_step(K_DONE, SRC_NONE, 1'b0, DST_NONE);
               end
            end
            PR_WDATA: begin
               seq[0] = mk_step(K_START, SRC_ADDR_WR, 1'b0, DST_NONE);
               seq[1] = mk_step(K_SEND,  SRC_CMD,     1'b0, DST_NONE);
               if (rd_i) begin
                  seq[2] = mk_step(K_START, SRC_ADDR_RD, 1'b0, DST_NONE);
                  seq[3] = mk_step(K_RECV,  SRC_NONE,    1'b0, DST_D0);
                  seq[4] = mk_step(K_RECV,  SRC_NONE,    1'b1, DST_D1);
                  seq[5] = mk_step(K_STOP,  SRC_NONE,    1'b0, DST_NONE);
                  seq[6] = mk_step(K_DONE,  SRC_NONE,    1'b0, DST_NONE);
               end else begin
                  seq[2] = mk_step(K_SEND, SRC_D0,   1'b0, DST_NONE);
                  seq[3] = mk_step(K_SEND, SRC_D1,   1'b0, DST_NONE);
                  seq[4] = mk_step(K_STOP, SRC_NONE, 1'b0, DST_NONE);
                  seq[5] = mk_step(K_DONE, SRC_NONE, 1'b0, DST_NONE);
               end
            end
            PR_BLOCK: begin
               seq[0] = mk_step(K_BLOCK, SRC_NONE, 1'b0, DST_NONE);
            end
            PR_IBLK: begin
               seq[0] = mk_step(K_START, SRC_ADDR_WR, 1'b0, DST_NONE);
               seq[1] = mk_step(K_SEND,  SRC_D1,      1'b0, DST_NONE);
               seq[2] = mk_step(K_START, SRC_ADDR_RD, 1'b0, DST_NONE);
               seq[3] = mk_step(K_RECV,  SRC_NONE,    1'b0, DST_BLK);
               seq[4] = mk_step(K_FIRST, SRC_NONE,    1'b0, DST_NONE);
            end
            default: ;
         endcase
      end
      step_o = seq[idx_i];
   end

endmodule

// File: rtl/smbseq_engine.sv
module smbseq_engine
   import smbseq_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PROTO_W     = 3,
   parameter int MAX_STEPS   = 8,
   parameter bit STOP_ON_NAK = 1'b1,
   localparam int IDX_W      = $clog2(MAX_STEPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_i,
   input  logic [PROTO_W-1:0] proto_i,
   input  logic [BYTE_W-1:0]  addr_i,
   input  logic [BYTE_W-1:0]  cmd_i,
   input  logic [BYTE_W-1:0]  data0_i,
   input  logic [BYTE_W-1:0]  data1_i,
   output logic [PROTO_W-1:0] proto_q_o,
   output logic               rd_q_o,
   output logic [IDX_W-1:0]   idx_o,
   input  step_t              step_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic               blk_go_o,
   output logic               first_byte_o,
   output logic [BYTE_W-1:0]  blk_byte_o,
   output logic               d0_we_o,
   output logic [BYTE_W-1:0]  d0_wdata_o,
   output logic               d1_we_o,
   output logic [BYTE_W-1:0]  d1_wdata_o,
   output logic               bm_valid_o,
   output logic [1:0]         bm_op_o,
   output logic [BYTE_W-1:0]  bm_byte_o,
   output logic               bm_nack_o,
   input  logic               bm_done_i,
   input  logic               bm_nak_i,
   input  logic [BYTE_W-1:0]  bm_rdata_i
);

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_ABORT} state_e;

   state_e              state;
   logic [IDX_W-1:0]    idx;
   logic [PROTO_W-1:0]  proto_q;
   logic [BYTE_W-1:0]   addr_q, cmd_q, d0_q, d1_q;
   logic [BYTE_W-1:0]   r0, r1, rblk;
   logic                got0, got1;
   logic                done_q, err_q, blk_q, first_q, d0we_q, d1we_q;
   logic                nak_abort;
   logic                is_bus_step;

   generate
      if (STOP_ON_NAK) begin : g_nak_stop
         assign nak_abort = 1'b1;
      end else begin : g_nak_drop
         assign nak_abort = 1'b0;
      end
   endgenerate

   assign is_bus_step = (step_i.kind == K_START) || (step_i.kind == K_SEND) ||
                        (step_i.kind == K_RECV)  || (step_i.kind == K_STOP);

   always_comb begin
      bm_valid_o = 1'b0;
      bm_op_o    = BM_STOP;
      bm_byte_o  = '0;
      bm_nack_o  = 1'b0;
      if (state == S_RUN && is_bus_step) begin
         bm_valid_o = 1'b1;
         bm_nack_o  = step_i.nack;
         case (step_i.kind)
            K_START: bm_op_o = BM_START;
            K_SEND:  bm_op_o = BM_SEND;
            K_RECV:  bm_op_o = BM_RECV;
            default: bm_op_o = BM_STOP;
         endcase
         case (step_i.src)
            SRC_ADDR_RAW: bm_byte_o = addr_q;
            SRC_ADDR_WR:  bm_byte_o = {addr_q[BYTE_W-1:1], 1'b0};
            SRC_ADDR_RD:  bm_byte_o = {addr_q[BYTE_W-1:1], 1'b1};
            SRC_CMD:      bm_byte_o = cmd_q;
            SRC_D0:       bm_byte_o = d0_q;
            SRC_D1:       bm_byte_o = d1_q;
            default:      bm_byte_o = '0;
         endcase
      end else if (state == S_ABORT) begin
         bm_valid_o = 1'b1;
         bm_op_o    = BM_STOP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         idx     <= '0;
         proto_q <= '0;
         addr_q  <= '0;
         cmd_q   <= '0;
         d0_q    <= '0;
         d1_q    <= '0;
         r0      <= '0;
         r1      <= '0;
         rblk    <= '0;
         got0    <= 1'b0;
         got1    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         blk_q   <= 1'b0;
         first_q <= 1'b0;
         d0we_q  <= 1'b0;
         d1we_q  <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         blk_q   <= 1'b0;
         first_q <= 1'b0;
         d0we_q  <= 1'b0;
         d1we_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (launch_i) begin
                  proto_q <= proto_i;
                  addr_q  <= addr_i;
                  cmd_q   <= cmd_i;
                  d0_q    <= data0_i;
                  d1_q    <= data1_i;
                  idx     <= '0;
                  got0    <= 1'b0;
                  got1    <= 1'b0;
                  state   <= S_RUN;
               end
            end
            S_RUN: begin
               case (step_i.kind)
                  K_START, K_SEND: begin
                     if (bm_done_i) begin
                        if (bm_nak_i) begin
                           if (nak_abort) begin
                              state <= S_ABORT;
                           end else begin
                              err_q <= 1'b1;
                              state <= S_IDLE;
                           end
                        end else begin
                           idx <= idx + 1'b1;
                        end
                     end
                  end
                  K_RECV: begin
                     if (bm_done_i) begin
                        case (step_i.dest)
                           DST_D0:  begin r0 <= bm_rdata_i; got0 <= 1'b1; end
                           DST_D1:  begin r1 <= bm_rdata_i; got1 <= 1'b1; end
                           DST_BLK: rblk <= bm_rdata_i;
                           default: ;
                        endcase
                        idx <= idx + 1'b1;
                     end
                  end
                  K_STOP: begin
                     if (bm_done_i) idx <= idx + 1'b1;
                  end
                  K_DONE: begin
                     done_q <= 1'b1;
                     d0we_q <= got0;
                     d1we_q <= got1;
                     state  <= S_IDLE;
                  end
                  K_BLOCK: begin
                     blk_q <= 1'b1;
                     state <= S_IDLE;
                  end
                  K_FIRST: begin
                     first_q <= 1'b1;
                     state   <= S_IDLE;
                  end
                  default: begin
                     err_q <= 1'b1;
                     state <= S_IDLE;
                  end
               endcase
            end
            S_ABORT: begin
               if (bm_done_i) begin
                  err_q <= 1'b1;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign proto_q_o    = proto_q;
   assign rd_q_o       = addr_q[0];
   assign idx_o        = idx;
   assign busy_o       = (state != S_IDLE);
   assign done_o       = done_q;
   assign err_o        = err_q;
   assign blk_go_o     = blk_q;
   assign first_byte_o = first_q;
   assign blk_byte_o   = rblk;
   assign d0_we_o      = d0we_q;
   assign d0_wdata_o   = r0;
   assign d1_we_o      = d1we_q;
   assign d1_wdata_o   = r1;

   assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_q, err_q, blk_q, first_q}));

   assert_idle_in_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q || err_q || blk_q || first_q) |-> !busy_o);

   assert_no_write_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !(d0we_q || d1we_q));

   assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_valid_o && !bm_done_i) |=> (bm_valid_o && $stable(bm_op_o) && $stable(bm_byte_o)));

   assert_word_pair_R12: assert property (@(posedge clk) disable iff (!rst_n)
      d1we_q |-> (d0we_q && done_q));

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
   import smbseq_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PROTO_W     = 3,
   parameter int MAX_STEPS   = 8,
   parameter bit STOP_ON_NAK = 1'b1,
   localparam int IDX_W      = $clog2(MAX_STEPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_i,
   input  logic [PROTO_W-1:0] proto_i,
   input  logic [BYTE_W-1:0]  addr_i,
   input  logic [BYTE_W-1:0]  cmd_i,
   input  logic [BYTE_W-1:0]  data0_i,
   input  logic [BYTE_W-1:0]  data1_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic               blk_go_o,
   output logic               first_byte_o,
   output logic [BYTE_W-1:0]  blk_byte_o,
   output logic               d0_we_o,
   output logic [BYTE_W-1:0]  d0_wdata_o,
   output logic               d1_we_o,
   output logic [BYTE_W-1:0]  d1_wdata_o,
   output logic               bm_valid_o,
   output logic [1:0]         bm_op_o,
   output logic [BYTE_W-1:0]  bm_byte_o,
   output logic               bm_nack_o,
   input  logic               bm_done_i,
   input  logic               bm_nak_i,
   input  logic [BYTE_W-1:0]  bm_rdata_i
);

   generate
      if (BYTE_W < 2) begin : g_chk_byte
         $error("BYTE_W must hold a read flag and an address");
      end
      if (PROTO_W < 3) begin : g_chk_proto
         $error("PROTO_W must hold all protocol codes");
      end
      if (MAX_STEPS < 7 || (MAX_STEPS & (MAX_STEPS - 1)) != 0) begin : g_chk_steps
         $error("MAX_STEPS must be a power of two of at least 7");
      end
   endgenerate

   logic [PROTO_W-1:0] proto_q;
   logic               rd_q;
   logic [IDX_W-1:0]   idx;
   step_t              step;

   smbseq_step_table #(
      .PROTO_W   (PROTO_W),
      .MAX_STEPS (MAX_STEPS)
   ) u_table (
      .proto_i (proto_q),
      .rd_i    (rd_q),
      .idx_i   (idx),
      .step_o  (step)
   );

   smbseq_engine #(
      .BYTE_W      (BYTE_W),
      .PROTO_W     (PROTO_W),
      .MAX_STEPS   (MAX_STEPS),
      .STOP_ON_NAK (STOP_ON_NAK)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_i     (launch_i),
      .proto_i      (proto_i),
      .addr_i       (addr_i),
      .cmd_i        (cmd_i),
      .data0_i      (data0_i),
      .data1_i      (data1_i),
      .proto_q_o    (proto_q),
      .rd_q_o       (rd_q),
      .idx_o        (idx),
      .step_i       (step),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .err_o        (err_o),
      .blk_go_o     (blk_go_o),
      .first_byte_o (first_byte_o),
      .blk_byte_o   (blk_byte_o),
      .d0_we_o      (d0_we_o),
      .d0_wdata_o   (d0_wdata_o),
      .d1_we_o      (d1_we_o),
      .d1_wdata_o   (d1_wdata_o),
      .bm_valid_o   (bm_valid_o),
      .bm_op_o      (bm_op_o),
      .bm_byte_o    (bm_byte_o),
      .bm_nack_o    (bm_nack_o),
      .bm_done_i    (bm_done_i),
      .bm_nak_i     (bm_nak_i),
      .bm_rdata_i   (bm_rdata_i)
   );

endmodule

// File: tb/tb_smbus_seq.sv
`timescale 1ns/1ps
module tb_smbus_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       launch = 1'b0;
   logic [2:0] proto = '0;
   logic [7:0] addr = '0, cmd = '0, d0 = '0, d1 = '0;
   logic       busy, done, err, blk_go, first;
   logic [7:0] blk_byte, d0_wd, d1_wd, bm_byte, bm_rdata;
   logic       d0_we, d1_we, bm_valid, bm_nack, bm_done, bm_nak;
   logic [1:0] bm_op;

   always #5 clk = ~clk;

   smbus_seq dut (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .proto_i(proto),
      .addr_i(addr), .cmd_i(cmd), .data0_i(d0), .data1_i(d1),
      .busy_o(busy), .done_o(done), .err_o(err), .blk_go_o(blk_go),
      .first_byte_o(first), .blk_byte_o(blk_byte),
      .d0_we_o(d0_we), .d0_wdata_o(d0_wd), .d1_we_o(d1_we), .d1_wdata_o(d1_wd),
      .bm_valid_o(bm_valid), .bm_op_o(bm_op), .bm_byte_o(bm_byte), .bm_nack_o(bm_nack),
      .bm_done_i(bm_done), .bm_nak_i(bm_nak), .bm_rdata_i(bm_rdata));

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fval(input int k);
      return 8'h3C ^ (8'(k) * 8'h11);
   endfunction

   // bus master model and request log
   logic [1:0] log_op [16];
   logic [7:0] log_byte [16];
   logic       log_nack [16];
   int log_n = 0, nak_at = -1, pend = 0, cnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         bm_done = 0; bm_nak = 0; bm_rdata = 0; pend = 0;
      end else if (bm_done) begin
         bm_done = 0; bm_nak = 0;
      end else if (bm_valid && pend == 0) begin
         if (log_n < 16) begin
            log_op[log_n] = bm_op; log_byte[log_n] = bm_byte; log_nack[log_n] = bm_nack;
         end
         log_n++; pend = 1; cnt = 2;
      end else if (pend != 0) begin
         cnt--;
         if (cnt == 0) begin
            pend = 0; bm_done = 1;
            bm_nak = ((log_n - 1) == nak_at) && (log_op[log_n-1] <= 2'd1);
            bm_rdata = fval(log_n - 1);
         end
      end
   end

   // result monitor
   int n_done = 0, n_err = 0, n_blk = 0, n_first = 0, n_d0 = 0, n_d1 = 0, bad_busy = 0;
   logic [7:0] last_d0 = 0, last_d1 = 0, last_blk = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) n_done++;
         if (err) n_err++;
         if (blk_go) n_blk++;
         if (first) begin n_first++; last_blk = blk_byte; end
         if (d0_we) begin n_d0++; last_d0 = d0_wd; end
         if (d1_we) begin n_d1++; last_d1 = d1_wd; end
         if ((done | err | blk_go | first) && busy) bad_busy++;
      end
   end

   // expectations
   logic [1:0] exp_op [16];
   logic [7:0] exp_byte [16];
   logic       exp_nack [16];
   int exp_n, exp_kind, exp_d0we, exp_d1we;
   logic [7:0] exp_r0, exp_r1, exp_blk;
   bit cut;

   task automatic push(input logic [1:0] op, input logic [7:0] b, input logic nk);
      if (cut) return;
      exp_op[exp_n] = op; exp_byte[exp_n] = b; exp_nack[exp_n] = nk;
      if (op <= 2'd1 && exp_n == nak_at) cut = 1;
      exp_n++;
   endtask

   task automatic build(input logic [2:0] p, input logic [7:0] a, c, x0, x1);
      logic [7:0] aw, ar;
      aw = {a[7:1], 1'b0}; ar = {a[7:1], 1'b1};
      cut = 0; exp_kind = 0; exp_d0we = 0; exp_d1we = 0;
      case (p)
         3'd0: begin push(0, a, 0); push(3, 0, 0); end
         3'd1: if (a[0]) begin push(0, ar, 0); exp_r0 = fval(exp_n); push(2, 0, 1); push(3, 0, 0); exp_d0we = 1; end
               else begin push(0, aw, 0); push(1, c, 0); push(3, 0, 0); end
         3'd2: if (a[0]) begin push(0, aw, 0); push(1, c, 0); push(0, ar, 0); exp_r0 = fval(exp_n);
                  push(2, 0, 1); push(3, 0, 0); exp_d0we = 1; end
               else begin push(0, aw, 0); push(1, c, 0); push(1, x0, 0); push(3, 0, 0); end
         3'd3: if (a[0]) begin push(0, aw, 0); push(1, c, 0); push(0, ar, 0); exp_r0 = fval(exp_n);
                  push(2, 0, 0); exp_r1 = fval(exp_n); push(2, 0, 1); push(3, 0, 0); exp_d0we = 1; exp_d1we = 1; end
               else begin push(0, aw, 0); push(1, c, 0); push(1, x0, 0); push(1, x1, 0); push(3, 0, 0); end
         3'd5: exp_kind = 2;
         3'd6: begin push(0, aw, 0); push(1, x1, 0); push(0, ar, 0); exp_blk = fval(exp_n); push(2, 0, 0); exp_kind = 3; end
         default: exp_kind = 1;
      endcase
      if (cut) begin
         exp_op[exp_n] = 2'd3; exp_byte[exp_n] = 0; exp_nack[exp_n] = 0; exp_n++;
         exp_kind = 1; exp_d0we = 0; exp_d1we = 0;
      end
   endtask

   task automatic clear_all();
      log_n = 0; exp_n = 0;
      n_done = 0; n_err = 0; n_blk = 0; n_first = 0; n_d0 = 0; n_d1 = 0; bad_busy = 0;
   endtask

   task automatic wait_outcome();
      for (int t = 0; t < 300; t++) begin
         @(negedge clk);
         if (done | err | blk_go | first) break;
      end
   endtask

   task automatic compare(input string req, input int nd, ne, nb, nf);
      chk(log_n == exp_n, req, "bus request count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(log_op[i] == exp_op[i], req, $sformatf("op[%0d]", i), log_op[i], exp_op[i]);
         if (exp_op[i] <= 2'd1)
            chk(log_byte[i] == exp_byte[i], req, $sformatf("byte[%0d]", i), log_byte[i], exp_byte[i]);
         if (exp_op[i] == 2'd2)
            chk(log_nack[i] == exp_nack[i], req, $sformatf("nack[%0d]", i), log_nack[i], exp_nack[i]);
      end
      chk(n_done == nd && n_err == ne && n_blk == nb && n_first == nf, req, "outcome pulses",
          {n_done[3:0], n_err[3:0], n_blk[3:0], n_first[3:0]}, {nd[3:0], ne[3:0], nb[3:0], nf[3:0]});
      chk(bad_busy == 0, "R10", "busy during result pulse", bad_busy, 0);
   endtask

   task automatic run_case(input string req, input logic [2:0] p, input logic [7:0] a, c, x0, x1,
                           input int nak, input bit inject);
      clear_all();
      nak_at = nak;
      build(p, a, c, x0, x1);
      @(negedge clk);
      proto = p; addr = a; cmd = c; d0 = x0; d1 = x1; launch = 1;
      @(negedge clk);
      launch = 0;
      chk(busy == 1'b1, "R10", "busy after launch", busy, 1);
      if (inject) begin
         repeat (3) @(negedge clk);
         proto = 3'd7; cmd = 8'hFF; addr = 8'h00; d0 = 8'h00; launch = 1;
         @(negedge clk);
         launch = 0;
      end
      wait_outcome();
      repeat (4) @(negedge clk);
      compare(req, exp_kind == 0, exp_kind == 1, exp_kind == 2, exp_kind == 3);
      chk(n_d0 == exp_d0we, "R12", "data0 write count", n_d0, exp_d0we);
      chk(n_d1 == exp_d1we, "R12", "data1 write count", n_d1, exp_d1we);
      if (exp_d0we != 0) chk(last_d0 == exp_r0, req, "data0 value", last_d0, exp_r0);
      if (exp_d1we != 0) chk(last_d1 == exp_r1, req, "data1 value", last_d1, exp_r1);
      if (exp_kind == 3) chk(last_blk == exp_blk, req, "first block byte", last_blk, exp_blk);
      nak_at = -1;
   endtask

   function automatic string tag_of(input logic [2:0] p);
      case (p)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd5: return "R7";
         3'd6: return "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && bm_valid == 0, "R1", "busy/request in reset", {busy, bm_valid}, 0);
      chk({done, err, blk_go, first, d0_we, d1_we} == 0, "R1", "pulses in reset",
          {done, err, blk_go, first, d0_we, d1_we}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && bm_valid == 0, "R1", "idle after reset", {busy, bm_valid}, 0);

      // sweep of every code, both read flags, two operand patterns
      for (int p = 0; p < 8; p++)
         for (int rd = 0; rd < 2; rd++)
            for (int pat = 0; pat < 2; pat++)
               run_case(tag_of(3'(p)), 3'(p),
                        {(pat != 0) ? 7'h52 : 7'h2D, 1'(rd)},
                        (pat != 0) ? 8'h9C : 8'h03,
                        8'h11 + 8'(p), 8'hE0 ^ {6'd0, 1'(rd), 1'(pat)}, -1, 0);

      // R9: not-acknowledge at each start/send position
      for (int k = 0; k < 4; k++) run_case("R9", 3'd3, 8'hA0, 8'h40, 8'h12, 8'h34, k, 0);
      for (int k = 0; k < 3; k++) run_case("R9", 3'd3, 8'hA1, 8'h40, 8'h12, 8'h34, k, 0);
      for (int k = 0; k < 3; k++) run_case("R9", 3'd6, 8'hA1, 8'h40, 8'h12, 8'h34, k, 0);
      for (int k = 0; k < 2; k++) run_case("R9", 3'd1, 8'h36, 8'h77, 8'h12, 8'h34, k, 0);
      run_case("R9", 3'd0, 8'h37, 8'h00, 8'h00, 8'h00, 0, 0);

      // R11: launch with other operands while busy is ignored
      run_case("R11", 3'd3, 8'hA1, 8'h40, 8'h12, 8'h34, -1, 1);
      run_case("R11", 3'd2, 8'h5C, 8'h81, 8'h6E, 8'h00, -1, 1);

      // R10: new launch in the same cycle as a done pulse
      clear_all();
      build(3'd1, 8'h51, 8'h00, 8'h00, 8'h00);
      @(negedge clk);
      proto = 3'd1; addr = 8'h51; launch = 1;
      @(negedge clk);
      launch = 0;
      wait_outcome();
      chk(done == 1'b1 && d0_we == 1'b1, "R10", "first done with data0 write", {done, d0_we}, 3);
      chk(d0_wd == exp_r0, "R3", "data0 in back-to-back", d0_wd, exp_r0);
      proto = 3'd0; addr = 8'h20; launch = 1;
      @(negedge clk);
      launch = 0;
      chk(busy == 1'b1, "R10", "launch accepted during done pulse", busy, 1);
      begin
         int base;
         base = exp_n;
         push(0, 8'h20, 0); push(3, 0, 0);
         wait_outcome();
         repeat (4) @(negedge clk);
         compare("R10", 2, 0, 0, 0);
         chk(exp_n == base + 2, "R10", "second sequence length", exp_n, base + 2);
      end
      chk(n_d0 == 1 && n_d1 == 0, "R12", "writes across back-to-back", {n_d0[3:0], n_d1[3:0]}, 8'h10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule